// File: doc/BRIEF.md
# Gated Fractional Clock Divider

This block produces one derived clock from a choice of parent clocks. Every parent arrives as a one-cycle tick strobe in the system clock domain, so a parent edge is a tick. The block picks one parent by index and counts its ticks. It emits an output tick each time a whole output period has gone by. The output period length is given by a divisor word in a 12.12 fixed-point layout. When a fraction is present, a first-order accumulator spreads the remainder, so the period alternates between the integer ratio and the integer ratio plus one.

Each instance is built with a fixed number of integer and fraction bits taken from the shared divisor word. The other bits of the word are ignored. An instance built with no divider bits at all is a plain pass-through of the chosen parent. A gate input turns the output on and off. The parent index and the divisor are only taken in while the gate is off, or at the start of an output period. This means a running period is never cut short and never stretched by a reconfiguration.

The parent list is ordered as follows. Index 0 is tied to ground. Index 1 is the reference oscillator. Indices 2 and 3 are test inputs. Higher indices are the functional sources. On display-interface instances, indices 4 to 9 carry a DDR clock, its inverse, a DDR2 clock, its inverse, a byte clock and its inverse, in that order.

Top module: `gated_frac_clkdiv`

## Requirements
- R1: After reset, outTick is low, the output period state is cleared and the selected parent is index 0.
- R2: With a zero fraction and an integer part I of 2 or more, the block asserts outTick once per I ticks of the selected parent. The first outTick after the gate opens follows the I-th tick. Each outTick is a one-cycle pulse that appears in the cycle after the parent tick that completes the period.
- R3: An integer part of 0 or 1 is treated as divide-by-1, so every selected parent tick produces an outTick.
- R4: Take a fraction field F that is FRAC_BITS wide. Counting from the gate opening, output period k lasts Ieff + floor(k*F/2^FRAC_BITS) - floor((k-1)*F/2^FRAC_BITS) parent ticks, where Ieff = max(I,1).
- R5: Only some divisor bits are used. The integer field is divisor[12 +: INT_BITS]. The fraction field is the top FRAC_BITS bits below bit 12, which is divisor[12-FRAC_BITS +: FRAC_BITS]. All other divisor bits have no effect on the output.
- R6: Parent index 0 is ground. It and any index of NUM_SRC or above yield no outTick, whatever srcTick[0] carries.
- R7: A srcSel value s from 1 to NUM_SRC-1 makes the block count srcTick[s] only.
- R8: While gateEn is low, outTick is low from the next cycle on. When the gate reopens, the period count and the fraction accumulator restart from zero.
- R9: If srcSel or divisor changes while the gate is open, the period in progress completes with the old settings. The new values apply from the next period on.
- R10: An instance built with INT_BITS = 0 and FRAC_BITS = 0 passes the selected parent through. With the gate open, outTick equals the selected tick of the previous cycle, and the divisor has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all parents are ticks in this domain |
| rstN | input | 1 | Active-low synchronous reset |
| gateEn | input | 1 | Output gate; low stops output and reloads settings |
| srcSel | input | $clog2(NUM_SRC) | Parent index (0 ground, 1 reference, 2-3 test, then sources) |
| divisor | input | 24 | 12.12 divide ratio, integer above bit 12 |
| srcTick | input | NUM_SRC | One tick strobe per parent clock |
| outTick | output | 1 | One-cycle pulse per derived output period |

## Verification
The main sweep runs every integer value of a 4.8 instance against seven fractions: zero, the smallest step, one half, one quarter, two irregular values and the largest fraction. The parent used ticks every other cycle, so the bench counts parent ticks and not cycles. The zero fraction isolates plain integer division, the small fractions show where the rare carry lands, and the dense ones show the alternation pattern. Integers 0 and 1 separate the divide-by-1 clamp from normal division. The unused divisor bits always carry nonzero filler, so any leak of those bits shows up as a wrong period. Separate runs cover each parent index, the ground and out-of-range indices, gate closing and reopening, reconfiguration in the middle of a period, and a pass-through instance compared cycle by cycle against the previous selected tick.

// File: rtl/gfd_pkg.sv
package gfd_pkg;
  localparam int DIV_W = 24;
  localparam int POINT = 12;

  typedef struct packed {
    logic reload;   // gate closed: restart and sample settings
    logic advance;  // a selected parent tick counted while gated on
    logic wrap;     // the tick that completes an output period
  } gfdStrobe_t;
endpackage

// File: rtl/gfd_ctrl.sv
module gfd_ctrl
  import gfd_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             gateEn,
  input  logic             parentTick,
  input  logic [LEN_W-1:0] curLen,
  output gfdStrobe_t       strb,
  output logic [LEN_W-1:0] cnt
);
  logic [LEN_W-1:0] cntInc;

  assign cntInc = LEN_W'(cnt + LEN_W'(1));

  always_comb begin
    strb.reload  = !gateEn;
    strb.advance = gateEn && parentTick;
    strb.wrap    = strb.advance && (cntInc == curLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.reload || strb.wrap) begin
      cnt <= '0;
    end else if (strb.advance) begin
      cnt <= cntInc;
    end
  end
endmodule

// File: rtl/gfd_datapath.sv
module gfd_datapath
  import gfd_pkg::*;
#(
  parameter int NUM_SRC   = 10,
  parameter int SEL_W     = 4,
  parameter int INT_BITS  = 4,
  parameter int FRAC_BITS = 8,
  parameter int LEN_W     = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic [DIV_W-1:0]   divisor,
  input  logic [NUM_SRC-1:0] srcTick,
  input  gfdStrobe_t         strb,
  output logic               parentTick,
  output logic [SEL_W-1:0]   activeSel,
  output logic [LEN_W-1:0]   curLen,
  output logic               outTick
);
  logic [LEN_W-1:0] intEff;
  logic             carry;
  logic             unusedInputs;

  assign unusedInputs = ^{divisor, srcTick[0]};

  // Parent multiplexer: index 0 and out-of-range indices read as ground.
  always_comb begin
    parentTick = 1'b0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (activeSel == SEL_W'(i)) parentTick = srcTick[i];
    end
  end

  // Integer part, clamped so that 0 and 1 both divide by one.
  generate
    if (INT_BITS > 0) begin : gInt
      logic [INT_BITS-1:0] intField;
      assign intField = divisor[POINT +: INT_BITS];
      assign intEff   = (intField <= INT_BITS'(1)) ? LEN_W'(1) : LEN_W'(intField);
    end else begin : gNoInt
      assign intEff = LEN_W'(1);
    end
  endgenerate

  // First-order fraction accumulator, one add per output period.
  generate
    if (FRAC_BITS > 0) begin : gFrac
      logic [FRAC_BITS-1:0] fracField;
      logic [FRAC_BITS-1:0] acc;
      logic [FRAC_BITS:0]   accSum;
      assign fracField = divisor[POINT-FRAC_BITS +: FRAC_BITS];
      assign accSum    = {1'b0, acc} + {1'b0, fracField};
      assign carry     = strb.reload ? 1'b0 : accSum[FRAC_BITS];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          acc <= '0;
        end else if (strb.reload) begin
          acc <= fracField;
        end else if (strb.wrap) begin
          acc <= accSum[FRAC_BITS-1:0];
        end
      end
    end else begin : gNoFrac
      assign carry = 1'b0;
    end
  endgenerate

  // Settings enter only with the gate closed or at a period boundary.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeSel <= '0;
      curLen    <= LEN_W'(1);
      outTick   <= 1'b0;
    end else begin
      if (strb.reload || strb.wrap) begin
        activeSel <= srcSel;
        curLen    <= LEN_W'(intEff + LEN_W'(carry));
      end
      outTick <= strb.wrap;
    end
  end
endmodule

// File: rtl/gated_frac_clkdiv.sv
module gated_frac_clkdiv
  import gfd_pkg::*;
#(
  parameter int NUM_SRC   = 10,
  parameter int INT_BITS  = 4,
  parameter int FRAC_BITS = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       gateEn,
  input  logic [$clog2(NUM_SRC)-1:0] srcSel,
  input  logic [DIV_W-1:0]           divisor,
  input  logic [NUM_SRC-1:0]         srcTick,
  output logic                       outTick
);
  localparam int SEL_W   = $clog2(NUM_SRC);
  localparam int LEN_W   = ((INT_BITS > 0) ? INT_BITS : 1) + 1;
  localparam int MAX_LEN = ((INT_BITS > 0) ? ((1 << INT_BITS) - 1) : 1) + 1;

  gfdStrobe_t       strb;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] curLen;
  logic [SEL_W-1:0] activeSel;
  logic             parentTick;

  gfd_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .gateEn     (gateEn),
    .parentTick (parentTick),
    .curLen     (curLen),
    .strb       (strb),
    .cnt        (cnt)
  );

  gfd_datapath #(
    .NUM_SRC   (NUM_SRC),
    .SEL_W     (SEL_W),
    .INT_BITS  (INT_BITS),
    .FRAC_BITS (FRAC_BITS),
    .LEN_W     (LEN_W)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .srcSel     (srcSel),
    .divisor    (divisor),
    .srcTick    (srcTick),
    .strb       (strb),
    .parentTick (parentTick),
    .activeSel  (activeSel),
    .curLen     (curLen),
    .outTick    (outTick)
  );
endmodule

// File: rtl/gated_frac_clkdiv_chk.sv
module gated_frac_clkdiv_chk #(
  parameter int SEL_W   = 4,
  parameter int LEN_W   = 5,
  parameter int MAX_LEN = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             gateEn,
  input logic             outTick,
  input logic             parentTick,
  input logic [SEL_W-1:0] activeSel,
  input logic [LEN_W-1:0] cnt,
  input logic [LEN_W-1:0] curLen,
  input logic             wrap
);
  p_gate_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !gateEn |=> !outTick);

  p_out_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    outTick |-> $past(parentTick && gateEn));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    cnt < curLen);

  p_len_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    (curLen >= LEN_W'(1)) && (32'(curLen) <= MAX_LEN));

  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeSel) |-> $past(!gateEn || wrap));
endmodule

bind gated_frac_clkdiv gated_frac_clkdiv_chk #(
  .SEL_W   (SEL_W),
  .LEN_W   (LEN_W),
  .MAX_LEN (MAX_LEN)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .gateEn     (gateEn),
  .outTick    (outTick),
  .parentTick (parentTick),
  .activeSel  (activeSel),
  .cnt        (cnt),
  .curLen     (curLen),
  .wrap       (strb.wrap)
);

// File: tb/gated_frac_clkdiv_test.sv
module gated_frac_clkdiv_test;
  localparam int NSRC = 10;

  logic            clk = 1'b0;
  logic            rstN;
  logic            gateEn;
  logic [3:0]      srcSel;
  logic [23:0]     divisor;
  logic [NSRC-1:0] srcTick;
  logic            outTick;
  logic            passTick;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int ticksSent = 0;
  bit prevSelTick = 0;
  bit passCheck = 0;
  int passMiss = 0;
  int passSeen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gated_frac_clkdiv #(.NUM_SRC(NSRC), .INT_BITS(4), .FRAC_BITS(8)) uut (
    .clk(clk), .rstN(rstN), .gateEn(gateEn), .srcSel(srcSel),
    .divisor(divisor), .srcTick(srcTick), .outTick(outTick));

  gated_frac_clkdiv #(.NUM_SRC(NSRC), .INT_BITS(0), .FRAC_BITS(0)) uutPass (
    .clk(clk), .rstN(rstN), .gateEn(gateEn), .srcSel(srcSel),
    .divisor(divisor), .srcTick(srcTick), .outTick(passTick));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit selValid();
    return (srcSel != 0) && (int'(srcSel) < NSRC);
  endfunction

  // Sample outputs, then drive the next parent ticks.
  task automatic step(output bit got, output int gap);
    @(negedge clk);
    got = outTick;
    gap = ticksSent;
    if (got) ticksSent = 0;
    if (passCheck) begin
      if (passTick !== (gateEn && prevSelTick)) passMiss++;
      if (passTick) passSeen++;
    end
    cyc++;
    srcTick[0] = 1'b1;
    for (int i = 1; i < NSRC; i++) srcTick[i] = ((cyc % i) == 0);
    prevSelTick = selValid() && srcTick[srcSel];
    if (prevSelTick) ticksSent++;
  endtask

  task automatic startRun(input int sel, input logic [23:0] div);
    bit g; int q;
    gateEn = 1'b0; srcSel = 4'(sel); divisor = div;
    step(g, q); step(g, q);
    ticksSent = 0;
    step(g, q);
    gateEn = 1'b1;
  endtask

  task automatic waitOut(output int gap, output bit ok);
    bit g; int q;
    ok = 0; gap = 0;
    for (int n = 0; n < 600; n++) begin
      step(g, q);
      if (g) begin ok = 1; gap = q; break; end
    end
  endtask

  function automatic int expLen(input int i, input int f, input int k);
    int ie;
    ie = (i <= 1) ? 1 : i;
    return ie + ((k * f) / 256) - (((k - 1) * f) / 256);
  endfunction

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit g; int q; bit ok; int gap; int cnt;
    int fracs[7];
    fracs = '{0, 1, 8'h40, 8'h80, 8'h55, 8'hC3, 8'hFF};
    rstN = 1'b0; gateEn = 1'b0; srcSel = '0; divisor = '0; srcTick = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outTick == 1'b0 && passTick == 1'b0, "R1 reset outputs", int'(outTick), 0);

    // Sweep integer and fraction on parent 2 (ticks every other cycle).
    // Unpopulated divisor bits carry filler (R5).
    for (int i = 0; i < 16; i++) begin
      for (int fi = 0; fi < 7; fi++) begin
        string req;
        if (i <= 1) req = "R3 R5 divide-by-1 clamp";
        else if (fracs[fi] == 0) req = "R2 R5 integer divide";
        else req = "R4 R5 fractional period";
        startRun(2, {4'hA, 4'(i), 8'(fracs[fi]), 4'h5});
        for (int k = 1; k <= 8; k++) begin
          waitOut(gap, ok);
          check(ok && gap == expLen(i, fracs[fi], k), req, gap, expLen(i, fracs[fi], k));
        end
      end
    end

    // Parent selection: each valid index counted on its own ticks (R7).
    for (int s = 1; s < NSRC; s++) begin
      startRun(s, {4'h0, 4'd3, 8'h00, 4'h0});
      for (int k = 0; k < 3; k++) begin
        waitOut(gap, ok);
        check(ok && gap == 3, "R7 parent select", gap, 3);
      end
    end

    // Ground and out-of-range indices (R6).
    for (int t = 0; t < 2; t++) begin
      startRun(t == 0 ? 0 : 12, {4'h0, 4'd2, 8'h00, 4'h0});
      cnt = 0;
      for (int n = 0; n < 120; n++) begin step(g, q); if (g) cnt++; end
      check(cnt == 0, "R6 ground or invalid parent", cnt, 0);
    end

    // Gate closing silences output; reopening restarts the count (R8).
    startRun(1, {4'h0, 4'd4, 8'h80, 4'h0});
    waitOut(gap, ok);
    waitOut(gap, ok);
    step(g, q);
    gateEn = 1'b0;
    cnt = 0;
    for (int n = 0; n < 50; n++) begin step(g, q); if (g) cnt++; end
    check(cnt == 0, "R8 gate closed output", cnt, 0);
    ticksSent = 0;
    step(g, q);
    gateEn = 1'b1;
    waitOut(gap, ok);
    check(ok && gap == 4, "R8 restart first period", gap, 4);
    waitOut(gap, ok);
    check(ok && gap == 5, "R8 accumulator restart", gap, 5);

    // Reconfiguration in the middle of a period (R9).
    startRun(1, {4'h0, 4'd8, 8'h00, 4'h0});
    waitOut(gap, ok);
    check(ok && gap == 8, "R9 first period", gap, 8);
    cnt = 0;
    for (int n = 0; n < 3; n++) begin step(g, q); cnt++; end
    divisor = {4'h0, 4'd3, 8'h00, 4'h0};
    srcSel = 4'd4;
    g = 0;
    for (int n = 0; n < 40 && !g; n++) begin step(g, q); cnt++; end
    check(g && cnt == 8, "R9 running period kept", cnt, 8);
    waitOut(gap, ok);
    check(ok && gap == 3, "R9 new settings next period", gap, 3);

    // Pass-through instance follows the selected parent (R10).
    for (int t = 0; t < 2; t++) begin
      startRun(t == 0 ? 3 : 7, t == 0 ? 24'h5A5A5A : 24'hFFF001);
      passMiss = 0; passSeen = 0; passCheck = 1;
      for (int n = 0; n < 60; n++) step(g, q);
      passCheck = 0;
      check(passMiss == 0, "R10 pass-through match", passMiss, 0);
      check(passSeen == 60 / (t == 0 ? 3 : 7), "R10 pass-through count", passSeen,
            60 / (t == 0 ? 3 : 7));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule